// File: doc/BRIEF.md
# NDRange Work-Item ID Generator

This block walks a three-dimensional index space and emits, one per clock, the coordinates of each work-item. A work-item is one execution of a data-parallel kernel. The space has range sizes in three dimensions and is divided into equal work-groups of a given size per dimension. For every item the block presents three coordinate sets in all three dimensions at once: the global id, the local id (the position inside the work-group) and the work-group id. The downstream consumer takes them through a valid/ready handshake, and a last flag marks the final item of the launch.

A launch begins with a one-cycle start pulse that captures the six sizes. The sizes are checked before anything is issued. Each size must be nonzero and each group size must divide its range exactly. If the check fails, the block raises a configuration error and issues nothing. Dimension 0 advances fastest and dimension 2 slowest. Local and group ids come from running counters, not from division.

Top module: `ndr_id_gen`

## Requirements
- R1: After a valid launch, the n-th accepted item (n counted from 0) carries global ids gid0 = n mod R0, gid1 = (n div R0) mod R1 and gid2 = n div (R0·R1). Every one of the R0·R1·R2 items is issued exactly once, with dimension 0 innermost.
- R2: For each dimension d, the local id equals gid_d mod G_d and the group id equals gid_d div G_d.
- R3: With range (9,3,6) and group size (3,3,3), the largest group ids seen during the launch are (2,0,1).
- R4: If any size is zero, or any G_d does not divide R_d, then cfg_err is 1 from the cycle after start and out_valid stays 0. cfg_err returns to 0 at the next start with a valid configuration.
- R5: While out_valid is 1 and out_ready is 0, out_valid and every id output hold their values.
- R6: last is 1 exactly on the final item. After that item is accepted, out_valid goes to 0.
- R7: A start pulse while a launch is in progress has no effect on the sequence of items.
- R8: A launch whose range is 1 in dimension 2 runs as a two-dimensional launch, with gid2, lid2 and wgid2 always 0.
- R9: After reset, out_valid, last and cfg_err are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch pulse; sizes are captured when it is seen while idle |
| range0 | input | 10 | Range size, dimension 0 |
| range1 | input | 10 | Range size, dimension 1 |
| range2 | input | 10 | Range size, dimension 2 |
| grp0 | input | 10 | Work-group size, dimension 0 |
| grp1 | input | 10 | Work-group size, dimension 1 |
| grp2 | input | 10 | Work-group size, dimension 2 |
| out_valid | output | 1 | An item is presented |
| out_ready | input | 1 | Consumer accepts the presented item |
| gid0 | output | 10 | Global id, dimension 0 |
| gid1 | output | 10 | Global id, dimension 1 |
| gid2 | output | 10 | Global id, dimension 2 |
| lid0 | output | 10 | Local id, dimension 0 |
| lid1 | output | 10 | Local id, dimension 1 |
| lid2 | output | 10 | Local id, dimension 2 |
| wgid0 | output | 10 | Work-group id, dimension 0 |
| wgid1 | output | 10 | Work-group id, dimension 1 |
| wgid2 | output | 10 | Work-group id, dimension 2 |
| last | output | 1 | Presented item is the final one |
| cfg_err | output | 1 | Last launch attempt had an invalid configuration |

## Verification
Random launches use group sizes from 1 to 4 and ranges that are small multiples of them. This exercises carries between dimensions and group wraps at many different periods. Random stall patterns on out_ready show whether items are held or skipped under backpressure. Directed cases cover the (9,3,6)/(3,3,3) split, a flat (N,N,1) launch, and a single-item launch where first and last coincide. A zero size and a non-dividing group size confirm that nothing is issued on a bad configuration. A start pulse injected mid-run shows that the launch in progress is not restarted.

// File: rtl/ndr_pkg.sv
package ndr_pkg;
  localparam int NDIM = 3;
  typedef enum logic { ST_IDLE = 1'b0, ST_RUN = 1'b1 } run_state_e;
endpackage

// File: rtl/ndr_div_check.sv
module ndr_div_check #(
  parameter int W = 10
) (
  input  logic [W-1:0] range_i,
  input  logic [W-1:0] grp_i,
  output logic         ok_o
);
  logic [W-1:0] rem;
  always_comb begin
    rem = '0;
    if (grp_i != '0) rem = range_i % grp_i;
    ok_o = (range_i != '0) && (grp_i != '0) && (rem == '0);
  end
endmodule

// File: rtl/ndr_dim_counter.sv
module ndr_dim_counter #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_i,
  input  logic         step_i,
  input  logic [W-1:0] range_i,
  input  logic [W-1:0] grp_i,
  output logic [W-1:0] gid_o,
  output logic [W-1:0] lid_o,
  output logic [W-1:0] wg_o,
  output logic         at_end_o
);
  logic grp_wrap;
  assign at_end_o = (gid_o == range_i - W'(1));
  assign grp_wrap = (lid_o == grp_i - W'(1));

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      gid_o <= '0;
      lid_o <= '0;
      wg_o  <= '0;
    end else if (step_i) begin
      if (at_end_o) begin
        gid_o <= '0;
        lid_o <= '0;
        wg_o  <= '0;
      end else begin
        gid_o <= gid_o + W'(1);
        lid_o <= grp_wrap ? '0 : lid_o + W'(1);
        wg_o  <= grp_wrap ? wg_o + W'(1) : wg_o;
      end
    end
  end

  AST_LID_BELOW_GRP: assert property (@(posedge clk) disable iff (rst)
    (grp_i != '0 && $past(clear_i)) |-> lid_o < grp_i); // R2
endmodule

// File: rtl/ndr_id_gen.sv
module ndr_id_gen #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] range0,
  input  logic [W-1:0] range1,
  input  logic [W-1:0] range2,
  input  logic [W-1:0] grp0,
  input  logic [W-1:0] grp1,
  input  logic [W-1:0] grp2,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] gid0,
  output logic [W-1:0] gid1,
  output logic [W-1:0] gid2,
  output logic [W-1:0] lid0,
  output logic [W-1:0] lid1,
  output logic [W-1:0] lid2,
  output logic [W-1:0] wgid0,
  output logic [W-1:0] wgid1,
  output logic [W-1:0] wgid2,
  output logic         last,
  output logic         cfg_err
);
  import ndr_pkg::*;

  logic [W-1:0] rng_in [NDIM];
  logic [W-1:0] grp_in [NDIM];
  logic [W-1:0] rng_q  [NDIM];
  logic [W-1:0] grp_q  [NDIM];
  logic [W-1:0] gid_w  [NDIM];
  logic [W-1:0] lid_w  [NDIM];
  logic [W-1:0] wg_w   [NDIM];
  logic [NDIM-1:0] dim_ok, dim_end, dim_step;

  run_state_e st;
  logic valid_q, err_q, fire, launch, all_ok, final_item;

  assign rng_in[0] = range0;
  assign rng_in[1] = range1;
  assign rng_in[2] = range2;
  assign grp_in[0] = grp0;
  assign grp_in[1] = grp1;
  assign grp_in[2] = grp2;

  assign fire       = valid_q & out_ready;
  assign launch     = start & (st == ST_IDLE);
  assign all_ok     = &dim_ok;
  assign final_item = valid_q & (&dim_end);

  always_comb begin
    dim_step[0] = fire;
    for (int d = 1; d < NDIM; d++) dim_step[d] = dim_step[d-1] & dim_end[d-1];
  end

  for (genvar d = 0; d < NDIM; d++) begin : g_dim
    ndr_div_check #(.W(W)) chk_i (
      .range_i (rng_in[d]),
      .grp_i   (grp_in[d]),
      .ok_o    (dim_ok[d])
    );
    ndr_dim_counter #(.W(W)) cnt_i (
      .clk      (clk),
      .rst      (rst),
      .clear_i  (launch & all_ok),
      .step_i   (dim_step[d]),
      .range_i  (rng_q[d]),
      .grp_i    (grp_q[d]),
      .gid_o    (gid_w[d]),
      .lid_o    (lid_w[d]),
      .wg_o     (wg_w[d]),
      .at_end_o (dim_end[d])
    );
    always_ff @(posedge clk) begin
      if (rst) begin
        rng_q[d] <= W'(1);
        grp_q[d] <= W'(1);
      end else if (launch) begin
        rng_q[d] <= rng_in[d];
        grp_q[d] <= grp_in[d];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      valid_q <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          if (all_ok) begin
            st      <= ST_RUN;
            valid_q <= 1'b1;
            err_q   <= 1'b0;
          end else begin
            err_q   <= 1'b1;
          end
        end
        ST_RUN: if (fire && final_item) begin
          st      <= ST_IDLE;
          valid_q <= 1'b0;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign out_valid = valid_q;
  assign cfg_err   = err_q;
  assign last      = final_item;
  assign gid0  = gid_w[0];
  assign gid1  = gid_w[1];
  assign gid2  = gid_w[2];
  assign lid0  = lid_w[0];
  assign lid1  = lid_w[1];
  assign lid2  = lid_w[2];
  assign wgid0 = wg_w[0];
  assign wgid1 = wg_w[1];
  assign wgid2 = wg_w[2];

  AST_HOLD_UNDER_STALL: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(gid0) && $stable(gid1) && $stable(gid2) && $stable(wgid0))); // R5
  AST_ERR_SILENT: assert property (@(posedge clk) disable iff (rst)
    cfg_err |-> !out_valid); // R4
  AST_DROP_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && last) |=> !out_valid); // R6
  AST_GID_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (gid0 < rng_q[0] && gid1 < rng_q[1] && gid2 < rng_q[2])); // R1
  AST_RESTART_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (out_valid && start && !(out_ready && last)) |=> out_valid); // R7
endmodule

// File: tb/ndr_id_gen_tb.sv
module ndr_id_gen_tb_top;
  localparam int W = 10;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic out_ready = 1'b0;
  logic [W-1:0] r0 = '0, r1 = '0, r2 = '0, g0 = '0, g1 = '0, g2 = '0;
  logic out_valid, last, cfg_err;
  logic [W-1:0] gid0, gid1, gid2, lid0, lid1, lid2, wgid0, wgid1, wgid2;

  int checks = 0;
  int errors = 0;
  int mx0, mx1, mx2;
  bit timed_out = 0;

  always #2.5 clk = ~clk;

  ndr_id_gen #(.W(W)) dut_i (
    .clk(clk), .rst(rst), .start(start),
    .range0(r0), .range1(r1), .range2(r2),
    .grp0(g0), .grp1(g1), .grp2(g2),
    .out_valid(out_valid), .out_ready(out_ready),
    .gid0(gid0), .gid1(gid1), .gid2(gid2),
    .lid0(lid0), .lid1(lid1), .lid2(lid2),
    .wgid0(wgid0), .wgid1(wgid1), .wgid2(wgid2),
    .last(last), .cfg_err(cfg_err)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit cfg_valid(input int a0, a1, a2, b0, b1, b2);
    if (a0 == 0 || a1 == 0 || a2 == 0 || b0 == 0 || b1 == 0 || b2 == 0) return 0;
    return (a0 % b0 == 0) && (a1 % b1 == 0) && (a2 % b2 == 0);
  endfunction

  task automatic pulse_start(input int a0, a1, a2, b0, b1, b2);
    @(negedge clk);
    r0 = W'(a0); r1 = W'(a1); r2 = W'(a2);
    g0 = W'(b0); g1 = W'(b1); g2 = W'(b2);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Runs a launch; stall_pct is the chance (0..100) of ready low per cycle.
  task automatic run_launch(input int a0, a1, a2, b0, b1, b2, input int stall_pct,
                            input bit poke_start, input bit flat);
    int total, n, e0, e1, e2, guard;
    total = a0 * a1 * a2;
    n = 0; guard = 0;
    mx0 = 0; mx1 = 0; mx2 = 0;
    pulse_start(a0, a1, a2, b0, b1, b2);
    check(cfg_err == 1'b0, "R4 err clear on good start", int'(cfg_err), 0);
    while (n < total && guard < 20000) begin
      guard++;
      start = 1'b0;
      if (!out_valid) begin
        check(0, "R1 valid dropped early", n, total);
        break;
      end
      e0 = n % a0; e1 = (n / a0) % a1; e2 = n / (a0 * a1);
      check(int'(gid0) == e0, "R1 gid0", int'(gid0), e0);
      check(int'(gid1) == e1, "R1 gid1", int'(gid1), e1);
      check(int'(gid2) == e2, "R1 gid2", int'(gid2), e2);
      check(int'(lid0) == e0 % b0 && int'(wgid0) == e0 / b0, "R2 dim0", int'(lid0) * 1024 + int'(wgid0), (e0 % b0) * 1024 + e0 / b0);
      check(int'(lid1) == e1 % b1 && int'(wgid1) == e1 / b1, "R2 dim1", int'(lid1) * 1024 + int'(wgid1), (e1 % b1) * 1024 + e1 / b1);
      check(int'(lid2) == e2 % b2 && int'(wgid2) == e2 / b2, "R2 dim2", int'(lid2) * 1024 + int'(wgid2), (e2 % b2) * 1024 + e2 / b2);
      check(last == (n == total - 1), "R6 last flag", int'(last), int'(n == total - 1));
      if (flat) check(gid2 == '0 && lid2 == '0 && wgid2 == '0, "R8 dim2 zero", int'(gid2), 0);
      if (int'(wgid0) > mx0) mx0 = int'(wgid0);
      if (int'(wgid1) > mx1) mx1 = int'(wgid1);
      if (int'(wgid2) > mx2) mx2 = int'(wgid2);
      out_ready = ($urandom_range(99) >= stall_pct);
      if (poke_start && n == total / 2) start = 1'b1; // R7: mid-run pulse
      if (out_ready) n++;
      @(negedge clk);
    end
    start = 1'b0;
    out_ready = 1'b0;
    check(n == total, "R1 item count", n, total);
    check(out_valid == 1'b0, "R6 valid low after last", int'(out_valid), 0);
    repeat (2) @(negedge clk);
    check(out_valid == 1'b0, "R7 no restart", int'(out_valid), 0);
  endtask

  task automatic bad_launch(input int a0, a1, a2, b0, b1, b2);
    pulse_start(a0, a1, a2, b0, b1, b2);
    out_ready = 1'b1;
    check(cfg_err == 1'b1, "R4 cfg_err raised", int'(cfg_err), 1);
    check(out_valid == 1'b0, "R4 no item", int'(out_valid), 0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && cfg_err == 1'b1, "R4 still silent", int'(out_valid), 0);
    out_ready = 1'b0;
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && last == 1'b0 && cfg_err == 1'b0, "R9 reset state", int'(out_valid), 0);

    run_launch(9, 3, 6, 3, 3, 3, 30, 0, 0);
    check(mx0 == 2 && mx1 == 0 && mx2 == 1, "R3 group counts", mx0 * 100 + mx1 * 10 + mx2, 201);

    run_launch(5, 5, 1, 1, 5, 1, 20, 0, 1);
    run_launch(1, 1, 1, 1, 1, 1, 50, 0, 0);
    run_launch(4, 2, 3, 2, 1, 3, 40, 1, 0);

    bad_launch(6, 4, 2, 4, 2, 2);
    bad_launch(0, 4, 2, 1, 2, 2);
    bad_launch(3, 3, 3, 3, 0, 3);

    for (int i = 0; i < 12; i++) begin
      int b0, b1, b2, a0, a1, a2;
      b0 = $urandom_range(4, 1); b1 = $urandom_range(4, 1); b2 = $urandom_range(4, 1);
      a0 = b0 * $urandom_range(3, 1); a1 = b1 * $urandom_range(3, 1); a2 = b2 * $urandom_range(3, 1);
      if (cfg_valid(a0, a1, a2, b0, b1, b2))
        run_launch(a0, a1, a2, b0, b1, b2, $urandom_range(60), i % 3 == 0, a2 == 1);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    timed_out = 1;
    checks++;
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule